// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control for a 10-bit successive-approximation converter. It produces a conversion clock, either by dividing the system clock by a power of two chosen with a 3-bit select field, or from the rising edges of a separate slow RC clock input. Software sets a GO request. The block then opens the sample switch and runs eleven conversion-clock periods: one setup period, then ten bit decisions. Each decision places a trial code on the output to an external DAC and reads back a comparator bit.

When the last decision is made, the block loads the 10-bit code into a high/low result register pair, in left- or right-justified form. In the same cycle it drops GO, closes the sample switch and raises a sticky completion flag. Clearing GO during a conversion aborts it. An abort leaves the results and the flag untouched.

Top module: `sar_seq`

## Requirements
- R1: Select codes give the conversion period as a number of system clocks: 000 gives 2, 100 gives 4, 001 gives 8, 101 gives 16, 010 gives 32, 110 gives 64.
- R2: Any select code whose two low bits are both 1 times the conversion from rising edges of `rc_clk` instead. `rc_clk` passes through a two-flop synchronizer first.
- R3: A conversion takes 11 conversion periods after a start delay of at most one period. The time from the `go_set` pulse to the flag lies between 11N+1 and 12N+1 system clocks, where N is the period.
- R4: The trial code resolves bits most significant first. The first nonzero trial is 0x200. A bit is kept when `cmp_in` is 1, meaning the input is at least the trial level, so the final code equals the modelled input.
- R5: `sample_on` is 0 while a conversion runs and 1 when idle.
- R6: In the cycle the flag rises, the results are loaded, `go` is already 0 and `sample_on` is already 1.
- R7: With `rjust` at 0 the result is left-justified: `res_hi` holds code bits 9..2, and `res_lo` holds bits 1..0 in its bits 7..6 with zeros below. With `rjust` at 1, `res_hi` holds bits 9..8 in its bits 1..0 and `res_lo` holds bits 7..0.
- R8: A `go_clr` pulse during a conversion stops it. `go` falls, `sample_on` rises, the results keep their value and the flag stays 0.
- R9: `done_flag` stays 1 until a `flag_clr` pulse clears it.
- R10: `cfg_wr` writes of `sel_in` and `rjust_in` are dropped while `go` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the select and justification settings |
| sel_in | input | 3 | Conversion clock select |
| rjust_in | input | 1 | 1 selects right justification |
| go_set | input | 1 | Start pulse |
| go_clr | input | 1 | Abort pulse |
| flag_clr | input | 1 | Clears the completion flag |
| rc_clk | input | 1 | Slow asynchronous RC clock |
| cmp_in | input | 1 | Comparator result, 1 when the input is at least the trial level |
| sample_on | output | 1 | Sample switch closed |
| trial_code | output | 10 | Trial code to the DAC |
| go | output | 1 | Conversion running |
| done_flag | output | 1 | Sticky completion flag |
| res_hi | output | 8 | High result register |
| res_lo | output | 8 | Low result register |

## Verification
The assertions assume the following about the inputs:
- `cmp_in` answers the current `trial_code` within the same system-clock cycle.
- The control strobes are single-cycle pulses that are low during reset.

The bench meets both assumptions. It derives `cmp_in` combinationally from an ideal comparison of a held input code against `trial_code`, and it drives every strobe for exactly one cycle between falling edges. `rc_clk` toggles every seven system clocks, which keeps it well below the synchronizer's limit, so no edge is lost.

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int DIV_W = 6,
  parameter int STEPS = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [2:0] sel_in,
  input  logic       rjust_in,
  input  logic       go_set,
  input  logic       go_clr,
  input  logic       flag_clr,
  input  logic       rc_clk,
  input  logic       cmp_in,
  output logic       sample_on,
  output logic [9:0] trial_code,
  output logic       go,
  output logic       done_flag,
  output logic [7:0] res_hi,
  output logic [7:0] res_lo
);
  localparam int CNT_W = $clog2(STEPS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS);

  logic [2:0] sel_q;
  logic       rjust_q;
  logic [DIV_W-1:0] div_cnt, div_mask;
  logic [2:0] rc_sh;
  logic [2:0] shamt;
  logic       tick, fin;
  logic [CNT_W-1:0] cnt;
  logic [9:0] mask, code_dec;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_q <= '0; rjust_q <= 1'b0;
    end else if (cfg_wr && !go) begin
      sel_q <= sel_in; rjust_q <= rjust_in;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_cnt <= '0; rc_sh <= '0;
    end else begin
      div_cnt <= div_cnt + 1'b1;
      rc_sh   <= {rc_sh[1:0], rc_clk};
    end

  assign shamt    = {sel_q[1:0], sel_q[2]} + 3'd1;
  assign div_mask = ~({DIV_W{1'b1}} << shamt);
  assign tick     = (&sel_q[1:0]) ? (rc_sh[1] & ~rc_sh[2]) : (&(div_cnt | ~div_mask));
  assign code_dec = cmp_in ? trial_code : (trial_code & ~mask);
  assign fin      = go && !go_clr && tick && cnt == LAST;
  assign sample_on = !go;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      go <= 1'b0; cnt <= '0; trial_code <= '0; mask <= '0;
      res_hi <= '0; res_lo <= '0;
    end else if (go && go_clr) begin
      go <= 1'b0; cnt <= '0; trial_code <= '0; mask <= '0;
    end else if (!go) begin
      if (go_set && !go_clr) begin
        go <= 1'b1; cnt <= '0;
      end
    end else if (tick) begin
      if (cnt == '0) cnt <= CNT_W'(1);
      else if (cnt == CNT_W'(1)) begin
        cnt <= CNT_W'(2); mask <= 10'h200; trial_code <= 10'h200;
      end else if (cnt == LAST) begin
        go <= 1'b0; cnt <= '0; trial_code <= '0; mask <= '0;
        if (rjust_q) begin
          res_hi <= {6'd0, code_dec[9:8]}; res_lo <= code_dec[7:0];
        end else begin
          res_hi <= code_dec[9:2]; res_lo <= {code_dec[1:0], 6'd0};
        end
      end else begin
        cnt <= cnt + 1'b1;
        mask <= mask >> 1;
        trial_code <= code_dec | (mask >> 1);
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) done_flag <= 1'b0;
    else if (fin) done_flag <= 1'b1;
    else if (flag_clr) done_flag <= 1'b0;

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done_flag) && !$past(flag_clr) |-> done_flag);
  assert_end_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> !go && sample_on && $past(go));
  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(go) && go |-> $stable(sel_q) && $stable(rjust_q));
  assert_abort_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    go && go_clr |=> $stable(res_hi) && $stable(res_lo) && !go);
  assert_onehot_trial_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask));
  assert_step_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: tb/tb_sar_seq.sv
module tb_sar_seq;
  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0, rjust_in = 0, go_set = 0, go_clr = 0, flag_clr = 0, rc_clk = 0, rc_run = 0;
  logic [2:0] sel_in = 0;
  logic [9:0] vin = 0;
  logic cmp_in, sample_on, go, done_flag;
  logic [9:0] trial_code;
  logic [7:0] res_hi, res_lo;
  int errors = 0, checks = 0;
  logic [15:0] exp_q[$];
  logic done_d = 0;

  always #5 clk = ~clk;
  assign cmp_in = (vin >= trial_code);

  sar_seq dut (.clk, .rst_n, .cfg_wr, .sel_in, .rjust_in, .go_set, .go_clr, .flag_clr,
               .rc_clk, .cmp_in, .sample_on, .trial_code, .go, .done_flag, .res_hi, .res_lo);

  initial forever begin
    repeat (7) @(posedge clk);
    if (rc_run) rc_clk = ~rc_clk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pack(input logic [9:0] v, input bit rj);
    return rj ? {6'd0, v[9:8], v[7:0]} : {v[9:2], v[1:0], 6'd0};
  endfunction

  always @(negedge clk) begin
    if (done_flag && !done_d) begin
      if (exp_q.size() == 0) chk(0, "R6 unexpected completion", {res_hi, res_lo}, 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk({res_hi, res_lo} == e, "R4/R7 result", {res_hi, res_lo}, e);
        chk(!go && sample_on, "R6 end state", {go, sample_on}, 1);
      end
    end
    done_d = done_flag;
  end

  task automatic pulse_flag_clr();
    flag_clr = 1; @(negedge clk); flag_clr = 0;
  endtask

  task automatic set_cfg(input logic [2:0] s, input bit rj);
    cfg_wr = 1; sel_in = s; rjust_in = rj; @(negedge clk); cfg_wr = 0;
  endtask

  task automatic convert(input logic [9:0] v, input bit rj, output int dur);
    logic [9:0] first_trial = 0;
    pulse_flag_clr();
    vin = v;
    exp_q.push_back(pack(v, rj));
    go_set = 1; @(negedge clk); go_set = 0;
    dur = 1;
    chk(go && !sample_on, "R5 sample open while running", sample_on, 0);
    while (!done_flag && dur < 5000) begin
      if (first_trial == 0 && trial_code != 0) first_trial = trial_code;
      @(negedge clk); dur++;
    end
    chk(first_trial == 10'h200, "R4 msb first", first_trial, 10'h200);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int d;
    repeat (3) @(negedge clk);
    chk(!go && !done_flag && sample_on && trial_code == 0 && res_hi == 0 && res_lo == 0,
        "R5 reset state", {go, done_flag, sample_on}, 1);
    rst_n = 1; @(negedge clk);

    set_cfg(3'b000, 0); convert(10'h2A5, 0, d);
    chk(d >= 23 && d <= 25, "R1 R3 div2 duration", d, 24);
    set_cfg(3'b100, 1); convert(10'h3FF, 1, d);
    chk(d >= 45 && d <= 49, "R1 R3 div4 duration", d, 46);
    set_cfg(3'b101, 0); convert(10'h000, 0, d);
    chk(d >= 177 && d <= 193, "R1 R3 div16 duration", d, 180);
    set_cfg(3'b110, 1); convert(10'h200, 1, d);
    chk(d >= 705 && d <= 769, "R1 R3 div64 duration", d, 720);
    set_cfg(3'b001, 0); convert(10'h155, 0, d);
    chk(d >= 89 && d <= 97, "R1 div8 duration", d, 90);
    set_cfg(3'b010, 1); convert(10'h0C3, 1, d);
    chk(d >= 353 && d <= 385, "R1 div32 duration", d, 360);

    repeat (50) @(negedge clk);
    chk(done_flag, "R9 flag held", done_flag, 1);
    pulse_flag_clr();
    chk(!done_flag, "R9 flag cleared", done_flag, 0);

    rc_run = 1;
    set_cfg(3'b011, 0); convert(10'h001, 0, d);
    chk(d >= 150 && d <= 175, "R2 rc clock duration", d, 160);
    set_cfg(3'b111, 1); convert(10'h3A7, 1, d);
    chk(d >= 150 && d <= 175, "R2 rc clock alt code", d, 160);
    rc_run = 0;

    set_cfg(3'b000, 0);
    pulse_flag_clr();
    vin = 10'h2A5;
    go_set = 1; @(negedge clk); go_set = 0;
    repeat (4) @(negedge clk);
    cfg_wr = 1; sel_in = 3'b110; rjust_in = 1; @(negedge clk); cfg_wr = 0;
    exp_q.push_back(pack(10'h2A5, 0));
    d = 6;
    while (!done_flag && d < 5000) begin @(negedge clk); d++; end
    chk(d <= 25, "R10 select write dropped", d, 24);
    convert(10'h111, 0, d);
    chk(d <= 25, "R10 select still div2", d, 24);

    set_cfg(3'b101, 1);
    pulse_flag_clr();
    vin = 10'h2F0;
    go_set = 1; @(negedge clk); go_set = 0;
    repeat (60) @(negedge clk);
    go_clr = 1; @(negedge clk); go_clr = 0;
    chk(!go && sample_on, "R8 abort stops", {go, sample_on}, 1);
    repeat (400) @(negedge clk);
    chk(!done_flag, "R8 no flag after abort", done_flag, 0);
    chk({res_hi, res_lo} == pack(10'h111, 0), "R8 results kept", {res_hi, res_lo}, pack(10'h111, 0));
    chk(exp_q.size() == 0, "R6 queue drained", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule